// File: doc/BRIEF.md
# Per-Bank Seven-Segment Glyph Decoder

This block turns a packed display word and a small configuration word into the eight anode levels for one digit position ("bank") of a multiplexed common-cathode LED display. The display word holds one 4-bit value per bank, a 3-bit code that picks which banks light the decimal point, and a brightness flag. The scan logic around the block presents a bank index each cycle. One clock later the block returns the segment pattern for that bank.

Every bank is decoded in one of three ways. Hexadecimal decode gives the digits 0-9 and the letters A-F. Glyph decode gives a fixed set of letters and symbols. Raw mode passes the value straight to four lamp outputs. The mode is chosen in two levels. A per-bank bit picks hexadecimal or "group choice". Then one group bit, shared by the lower banks, and a second group bit, shared by the upper banks, choose between glyph and raw. The decimal-point output is decoded the same way in all three modes.

Top module: `seg_bank_decoder`

## Requirements
- R1: While `rstN` is low, `segOut` and `brightOut` are 0 from the first rising clock edge on.
- R2: The outputs are registered. `segOut` and `brightOut` show the inputs sampled at the previous rising edge of `clk`, and they do not change between edges. In `segOut`, bit 0 is segment a, bit 6 is segment g and bit 7 is the decimal point h. A 1 means the segment is lit.
- R3: Bank k (where `bankSel` = k, 0 to 4) decodes the value in `dispWord[4k+3:4k]`, and no other value field affects it.
- R4: Bank k decodes in hexadecimal when `cfgWord[k+1]` is 0. When that bit is 1, the mode comes from a group bit: `cfgWord[6]` for banks 0 to 2 and `cfgWord[7]` for banks 3 and 4. A group bit of 1 gives glyph decode and 0 gives raw. `cfgWord[0]` has no effect on the outputs.
- R5: Hexadecimal decode maps values 0 to F to `segOut[6:0]` = 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71.
- R6: Glyph decode maps values 0 to F to `segOut[6:0]` = 00 (blank), 58 (c), 76 (H), 74 (h), 1E (J), 38 (L), 54 (n), 5C (o), 73 (P), 50 (r), 3E (U), 1C (u), 6E (y), 40 (-), 48 (=), 63 (degree).
- R7: In raw mode, `segOut[3:0]` equals the bank's value bits and `segOut[6:4]` is 0.
- R8: The h code `dispWord[22:20]` lights `segOut[7]` for bank k as follows. Code 0 lights no bank. Codes 1 to 5 light only bank code-1. Code 6 lights banks 0 and 1. Code 7 lights every bank.
- R9: The decimal-point result of R8 is the same whichever decode mode the bank uses.
- R10: `brightOut` equals `dispWord[23]` (1 = bright, 0 = dim) for every `bankSel`, including values outside 0 to 4.
- R11: When `bankSel` is 5, 6 or 7, `segOut` is all zeros, whatever the h code is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bankSel | input | 3 | Index of the bank to decode |
| dispWord | input | 24 | Bank values, h code and brightness flag |
| cfgWord | input | 8 | Per-bank mode bits and the two group bits |
| segOut | output | 8 | Registered anode pattern, a in bit 0 to h in bit 7 |
| brightOut | output | 1 | Registered brightness flag |

## Verification
The bench builds the block with its default parameters: five banks, a 3-bit bank index and a three-bank lower group. At this size every configuration word can be tried against every bank index, including the three indexes that name no bank. Dedicated sweeps then run all sixteen values through each decode mode on every bank, while the neighbouring fields hold different values and the h code and brightness flag rotate. These sweeps reach every table entry and every h code for each bank.

// File: rtl/seg_decode_pkg.sv
package seg_decode_pkg;

  localparam int NIBBLE_W = 4;
  localparam int BODY_W   = 7;
  localparam int SEG_W    = BODY_W + 1;
  localparam int HCODE_W  = 3;

  typedef enum logic [1:0] {
    DEC_HEX   = 2'd0,
    DEC_GLYPH = 2'd1,
    DEC_RAW   = 2'd2
  } decMode_e;

  // Strobes from control to datapath for the bank being decoded
  typedef struct packed {
    logic     bankValid;
    decMode_e mode;
    logic     hLit;
  } bankCtl_t;

  // Letters and symbols, segment a in bit 0
  localparam logic [BODY_W-1:0] GLYPH_TABLE [16] = '{
    7'h00, 7'h58, 7'h76, 7'h74, 7'h1E, 7'h38, 7'h54, 7'h5C,
    7'h73, 7'h50, 7'h3E, 7'h1C, 7'h6E, 7'h40, 7'h48, 7'h63
  };

  function automatic logic [BODY_W-1:0] hexBody(input logic [NIBBLE_W-1:0] v);
    logic [BODY_W-1:0] r;
    case (v)
      4'h0: r = 7'h3F;
      4'h1: r = 7'h06;
      4'h2: r = 7'h5B;
      4'h3: r = 7'h4F;
      4'h4: r = 7'h66;
      4'h5: r = 7'h6D;
      4'h6: r = 7'h7D;
      4'h7: r = 7'h07;
      4'h8: r = 7'h7F;
      4'h9: r = 7'h6F;
      4'hA: r = 7'h77;
      4'hB: r = 7'h7C;
      4'hC: r = 7'h39;
      4'hD: r = 7'h5E;
      4'hE: r = 7'h79;
      default: r = 7'h71;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/seg_decode_ctrl.sv
module seg_decode_ctrl
  import seg_decode_pkg::*;
#(
  parameter int NUM_BANKS     = 5,
  parameter int BANK_SEL_W    = 3,
  parameter int GROUP_A_BANKS = 3
) (
  input  logic [BANK_SEL_W-1:0] bankSel,
  input  logic [NUM_BANKS+2:1]  cfgBits,
  input  logic [HCODE_W-1:0]    hCode,
  output bankCtl_t              ctl
);

  localparam int GROUP_A_BIT = NUM_BANKS + 1;
  localparam int GROUP_B_BIT = NUM_BANKS + 2;

  decMode_e              modeVec [NUM_BANKS];
  logic [NUM_BANKS-1:0]  hVec;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int   GROUP_BIT = (b < GROUP_A_BANKS) ? GROUP_A_BIT : GROUP_B_BIT;
      localparam logic IN_PAIR   = (b < 2);
      assign modeVec[b] = !cfgBits[b+1]       ? DEC_HEX :
                          cfgBits[GROUP_BIT]  ? DEC_GLYPH : DEC_RAW;
      assign hVec[b] = (hCode == 3'd7)
                     || ((hCode == 3'd6) && IN_PAIR)
                     || (hCode == HCODE_W'(b + 1));
    end
  endgenerate

  always_comb begin
    ctl = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(bankSel) == b) begin
        ctl.bankValid = 1'b1;
        ctl.mode      = modeVec[b];
        ctl.hLit      = hVec[b];
      end
    end
  end

endmodule

// File: rtl/seg_decode_dp.sv
module seg_decode_dp
  import seg_decode_pkg::*;
#(
  parameter int NUM_BANKS  = 5,
  parameter int BANK_SEL_W = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [BANK_SEL_W-1:0]         bankSel,
  input  logic [NUM_BANKS*NIBBLE_W-1:0] nibbleField,
  input  logic                          brightIn,
  input  bankCtl_t                      ctl,
  output logic [SEG_W-1:0]              segOut,
  output logic                          brightOut
);

  logic [NIBBLE_W-1:0] nibble;
  logic [BODY_W-1:0]   body;
  logic [SEG_W-1:0]    nextSeg;

  always_comb begin
    nibble = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(bankSel) == b) nibble = nibbleField[b*NIBBLE_W +: NIBBLE_W];
    end
  end

  always_comb begin
    case (ctl.mode)
      DEC_HEX:   body = hexBody(nibble);
      DEC_GLYPH: body = GLYPH_TABLE[nibble];
      default:   body = {{(BODY_W-NIBBLE_W){1'b0}}, nibble};
    endcase
  end

  assign nextSeg = ctl.bankValid ? {ctl.hLit, body} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segOut    <= '0;
      brightOut <= 1'b0;
    end else begin
      segOut    <= nextSeg;
      brightOut <= brightIn;
    end
  end

endmodule

// File: rtl/seg_bank_decoder.sv
module seg_bank_decoder
  import seg_decode_pkg::*;
#(
  parameter int NUM_BANKS     = 5,
  parameter int BANK_SEL_W    = 3,
  parameter int GROUP_A_BANKS = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [BANK_SEL_W-1:0]         bankSel,
  input  logic [NUM_BANKS*4+3:0]        dispWord,
  input  logic [NUM_BANKS+2:0]          cfgWord,
  output logic [7:0]                    segOut,
  output logic                          brightOut
);

  localparam int NIB_TOP   = NUM_BANKS * NIBBLE_W;
  localparam int BRIGHT_IX = NIB_TOP + HCODE_W;

  bankCtl_t ctl;

  seg_decode_ctrl #(
    .NUM_BANKS(NUM_BANKS), .BANK_SEL_W(BANK_SEL_W), .GROUP_A_BANKS(GROUP_A_BANKS)
  ) i_ctrl (
    .bankSel (bankSel),
    .cfgBits (cfgWord[NUM_BANKS+2:1]),
    .hCode   (dispWord[NIB_TOP +: HCODE_W]),
    .ctl     (ctl)
  );

  seg_decode_dp #(
    .NUM_BANKS(NUM_BANKS), .BANK_SEL_W(BANK_SEL_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .bankSel     (bankSel),
    .nibbleField (dispWord[NIB_TOP-1:0]),
    .brightIn    (dispWord[BRIGHT_IX]),
    .ctl         (ctl),
    .segOut      (segOut),
    .brightOut   (brightOut)
  );

endmodule

// File: rtl/seg_bank_decoder_chk.sv
module seg_bank_decoder_chk #(
  parameter int NUM_BANKS  = 5,
  parameter int BANK_SEL_W = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [BANK_SEL_W-1:0] bankSel,
  input logic [3:0]            nib0,
  input logic [2:0]            hCode,
  input logic                  bank0Bit,
  input logic                  groupABit,
  input logic [7:0]            segOut,
  input logic                  brightOut
);

  logic sawEdge = 1'b0;
  always @(posedge clk) sawEdge <= 1'b1;

  // R1
  always @(negedge clk) begin
    if (sawEdge && !rstN) begin
      reset_clear_chk: assert (segOut == 8'h00 && brightOut == 1'b0);
    end
  end

  // R11
  bank_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(bankSel) >= NUM_BANKS) |=> (segOut == 8'h00));

  // R7
  raw_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankSel == '0 && bank0Bit && !groupABit) |=> (segOut[6:4] == 3'b000));

  // R7
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankSel == '0 && bank0Bit && !groupABit) |=> (segOut[3:0] == $past(nib0)));

  // R8
  h_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hCode == 3'd0) |=> !segOut[7]);

  // R8
  h_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hCode == 3'd7 && int'(bankSel) < NUM_BANKS) |=> segOut[7]);

endmodule

bind seg_bank_decoder seg_bank_decoder_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_SEL_W(BANK_SEL_W)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bankSel   (bankSel),
  .nib0      (dispWord[3:0]),
  .hCode     (dispWord[NUM_BANKS*4 +: 3]),
  .bank0Bit  (cfgWord[1]),
  .groupABit (cfgWord[NUM_BANKS+1]),
  .segOut    (segOut),
  .brightOut (brightOut)
);

// File: tb/test_seg_bank_decoder.sv
module test_seg_bank_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  bankSel = '0;
  logic [23:0] dispWord = '0;
  logic [7:0]  cfgWord = '0;
  logic [7:0]  segOut;
  logic        brightOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_bank_decoder i_seg_bank_decoder (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .dispWord(dispWord),
    .cfgWord(cfgWord), .segOut(segOut), .brightOut(brightOut)
  );

  // R5 table
  localparam logic [6:0] HEX_T [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
    7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71
  };
  // R6 table
  localparam logic [6:0] GLY_T [16] = '{
    7'h00, 7'h58, 7'h76, 7'h74, 7'h1E, 7'h38, 7'h54, 7'h5C,
    7'h73, 7'h50, 7'h3E, 7'h1C, 7'h6E, 7'h40, 7'h48, 7'h63
  };

  function automatic logic [7:0] expSeg(int bank, logic [23:0] d, logic [7:0] c);
    logic [3:0] nib;
    logic [6:0] body;
    logic       grp;
    logic       h;
    int         code;
    if (bank >= 5) return 8'h00;
    nib  = d[bank*4 +: 4];
    grp  = (bank < 3) ? c[6] : c[7];
    body = !c[bank+1] ? HEX_T[nib] : (grp ? GLY_T[nib] : {3'b000, nib});
    code = int'(d[22:20]);
    h    = (code == 7) || (code == 6 && bank < 2) || (code == bank + 1);
    return {h, body};
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, int bank, logic [23:0] d, logic [7:0] c);
    @(negedge clk);
    bankSel  = 3'(bank);
    dispWord = d;
    cfgWord  = c;
    @(posedge clk);
    #1;
    check8(tag, segOut, expSeg(bank, d, c));
    check8("R10", {7'b0, brightOut}, {7'b0, d[23]});
  endtask

  function automatic logic [23:0] mixWord(int bank, int nib, int salt);
    logic [23:0] d;
    d = '0;
    for (int b = 0; b < 5; b++) d[b*4 +: 4] = 4'((nib + 3*(b - bank) + salt) & 15);
    d[22:20] = 3'(nib + salt);
    d[23]    = 1'((nib + bank) & 1);
    return d;
  endfunction

  initial begin
    // R1: hold reset with busy inputs
    bankSel = 3'd1; dispWord = 24'hFFFFFF; cfgWord = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    check8("R1", segOut, 8'h00);
    check8("R1", {7'b0, brightOut}, 8'h00);
    @(negedge clk) rstN = 1'b1;

    // R5 hex decode on every bank, with R3 neighbours differing and R8/R9 codes rotating
    for (int bank = 0; bank < 5; bank++)
      for (int nib = 0; nib < 16; nib++)
        apply("R5/R3/R8", bank, mixWord(bank, nib, 0), 8'h00);

    // R6 glyph decode on every bank
    for (int bank = 0; bank < 5; bank++)
      for (int nib = 0; nib < 16; nib++)
        apply("R6/R3/R9", bank, mixWord(bank, nib, 5), 8'hFE);

    // R7 raw mode on every bank
    for (int bank = 0; bank < 5; bank++)
      for (int nib = 0; nib < 16; nib++)
        apply("R7/R3/R9", bank, mixWord(bank, nib, 2), 8'h3E);

    // R4 and R11: every configuration word against every bank index
    for (int c = 0; c < 256; c++)
      for (int bank = 0; bank < 8; bank++)
        apply("R4/R11", bank, 24'((c * 40503 + bank * 977) ^ (c << 13)), 8'(c));

    // R4: cfgWord bit 0 ignored
    apply("R4", 2, 24'h5A3C71, 8'h1F);
    apply("R4", 2, 24'h5A3C71, 8'h1E);

    // R8: code 6 lights banks 0 and 1 only
    for (int bank = 0; bank < 5; bank++)
      apply("R8", bank, 24'h6ABCDE, 8'hC0);

    // R11: out-of-range bank with all-h code and bright set
    apply("R11", 5, 24'hF12345, 8'hFF);
    apply("R11", 7, 24'hF88888, 8'h00);

    // R2: output holds between edges, then changes one edge later
    apply("R2", 0, 24'h000008, 8'h00);
    @(negedge clk);
    bankSel = 3'd0; dispWord = 24'h000001; cfgWord = 8'h00;
    #1;
    check8("R2", segOut, 8'h7F);
    @(posedge clk);
    #1;
    check8("R2", segOut, 8'h06);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule